// File: doc/BRIEF.md
# Converter Power-Mode Wake Sequencer

This block sits between a system controller and a sampling converter and owns the converter's two low-power control lines. A two-bit requested power state selects whether the converter runs, dozes with the reference kept alive (light sleep), or shuts down fully (deep sleep). When the converter is brought back to the running state, the block holds a ready flag low for a wake-up delay and lets no convert-start request through until that delay has elapsed. A converter started earlier would return invalid data.

The delay depends on the state being left and on a reference-source input. Leaving light sleep always uses the short delay. Leaving deep sleep uses a long delay with the on-chip reference and a medium delay with an external reference that stayed powered. Light sleep needs an external reference, so a light-sleep request while the on-chip reference is selected is refused and sets a sticky error flag.

An optional auto-doze mode trades throughput for power. When the converter's busy line rises, the block drives light sleep. It then wakes the converter in time for the converter to be ready exactly one conversion period after the last issued start. All delays and the period are parameters counted in clock cycles.

Top module: `pw_wake_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the light-sleep output, deep-sleep output and error flag are low, the ready flag is high and no convert-start is forwarded without a request.
- R2: The request code is sampled at each clock edge: 2'b00 asks for running, 2'b01 for light sleep and 2'b10 or 2'b11 for deep sleep. The matching sleep output is high from the following cycle. The two sleep outputs are never high together, and the ready flag is low while either of them is high.
- R3: When running is requested while in light sleep, the light-sleep output drops after that edge. The ready flag stays low for NAP_WAKE_CYC cycles and rises in the cycle after those cycles.
- R4: When leaving deep sleep with ref_ext_i low (on-chip reference), ready rises after STBY_INT_CYC low cycles, counted as in R3.
- R5: When leaving deep sleep with ref_ext_i high (external reference), ready rises after STBY_EXT_CYC low cycles, counted as in R3.
- R6: conv_go_o is high in exactly the cycles in which conv_req_i and the ready flag are both high. A request while ready is low has no effect.
- R7: A light-sleep request while ref_ext_i is low leaves the power state unchanged and raises err_o at the next edge.
- R8: err_o stays high until the next reset.
- R9: With auto_nap_i and ref_ext_i high, a rise of busy_i while running sets the light-sleep output from the next cycle and holds ready low.
- R10: In auto-doze, if conv_go_o was high in cycle c, light sleep is released early enough that ready rises again exactly in cycle c + CONV_PERIOD_CYC.
- R11: A busy rise seen when CONV_PERIOD_CYC - NAP_WAKE_CYC - 2 or more cycles have elapsed since the last forwarded start does not enter auto-doze.
- R12: A busy rise with auto_nap_i high and ref_ext_i low does not enter light sleep and raises err_o.
- R13: A deep-sleep request sampled at the same edge as a busy rise wins: deep sleep is entered, auto-doze is not. The later exit follows R4/R5.
- R14: Dropping auto_nap_i during auto-doze releases light sleep at the next edge and ready follows the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req_i | input | 2 | Requested power state (00 run, 01 light sleep, 1x deep sleep) |
| ref_ext_i | input | 1 | 1 = external reference, 0 = on-chip reference |
| auto_nap_i | input | 1 | Enables automatic light sleep after each conversion |
| conv_req_i | input | 1 | Convert-start request from the controller |
| busy_i | input | 1 | Converter busy line |
| nap_o | output | 1 | Light-sleep control line |
| stby_o | output | 1 | Deep-sleep control line |
| ready_o | output | 1 | Converter awake and settled |
| conv_go_o | output | 1 | Gated convert-start to the conversion controller |
| err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The auto-doze entry on a busy rise and a manual deep-sleep request can land on the same clock edge. The bench raises busy_i and drives the deep-sleep code in one cycle. It then checks that only the deep-sleep line is high afterwards, and that the exit uses the deep-sleep delay rather than the light-sleep one. A second collision is the busy rise that arrives exactly at the auto-doze cut-off. The bench sweeps that rise over the cycles on both sides of the cut-off and judges each case by whether light sleep appears.

// File: rtl/pw_seq_pkg.sv
// Shared types for the power-mode wake sequencer.
// Assumes: a two-bit request code where the upper bit forces deep sleep.
package pw_seq_pkg;

    typedef enum logic [1:0] {
        PW_ACTIVE = 2'd0,
        PW_NAP    = 2'd1,
        PW_STBY   = 2'd2
    } pw_state_t;

    // Map the raw request code onto a power state.
    function automatic pw_state_t decode_req(input logic [1:0] code);
        pw_state_t s;
        if (code[1])
            s = PW_STBY;
        else if (code[0])
            s = PW_NAP;
        else
            s = PW_ACTIVE;
        return s;
    endfunction

endpackage

// File: rtl/pw_state_ctrl.sv
// Power-state register with request legality check and wake-delay select.
// Refuses light sleep when the on-chip reference is selected and keeps a
// sticky error flag. Assumes a counter downstream that consumes the
// wake load pulse and delay value.
module pw_state_ctrl
    import pw_seq_pkg::*;
#(
    parameter int unsigned NAP_WAKE = 60,
    parameter int unsigned STBY_INT = 1000,
    parameter int unsigned STBY_EXT = 100,
    parameter int unsigned CW       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req_i,
    input  logic            ref_ext_i,
    input  logic            bad_i,
    output pw_state_t       state_o,
    output pw_state_t       next_o,
    output logic            wake_load_o,
    output logic [CW-1:0]   wake_val_o,
    output logic            err_o
);

    pw_state_t state_q;
    pw_state_t target;
    pw_state_t next_s;
    logic      illegal;
    logic      err_q;

    // Decode the request and reject light sleep on the on-chip reference.
    always_comb begin
        target  = decode_req(req_i);
        illegal = (target == PW_NAP) && !ref_ext_i;
        next_s  = illegal ? state_q : target;
    end

    // Pick the wake delay from the state being left and the reference source.
    always_comb begin
        wake_load_o = (state_q != PW_ACTIVE) && (next_s == PW_ACTIVE);
        if (state_q == PW_NAP)
            wake_val_o = CW'(NAP_WAKE);
        else if (ref_ext_i)
            wake_val_o = CW'(STBY_EXT);
        else
            wake_val_o = CW'(STBY_INT);
    end

    // Hold the current power state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PW_ACTIVE;
        else
            state_q <= next_s;
    end

    // Sticky error: set by any refused request or illegal auto-doze attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= err_q | illegal | bad_i;
    end

    assign state_o = state_q;
    assign next_o  = next_s;
    assign err_o   = err_q;

endmodule

// File: rtl/pw_wake_timer.sv
// Down-counter for the wake-up delay. It reports busy while the count is
// non-zero. A clear wins over a load; a load wins over counting.
module pw_wake_timer #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          busy_o
);

    logic [CW-1:0] cnt_q;

    // Load, clear or count down the remaining wake cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/pw_autonap.sv
// Auto-doze scheduler. It enters light sleep on a busy rise and releases it
// so that the following wake delay ends one conversion period after the
// last forwarded start. Assumes PERIOD exceeds NAP_WAKE by at least 3.
module pw_autonap #(
    parameter int unsigned PERIOD   = 400,
    parameter int unsigned NAP_WAKE = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ref_ext_i,
    input  logic active_i,
    input  logic kill_i,
    input  logic busy_i,
    input  logic conv_go_i,
    output logic hold_o,
    output logic release_o,
    output logic bad_o
);

    localparam int unsigned SW     = $clog2(PERIOD + 1);
    localparam int unsigned REL_AT = (PERIOD > NAP_WAKE + 2) ? (PERIOD - NAP_WAKE - 2) : 0;

    logic          busy_q;
    logic          hold_q;
    logic [SW-1:0] since_q;
    logic          rise;
    logic          late;
    logic          enter;

    // Edge detect, schedule position and entry/release decisions.
    always_comb begin
        rise      = busy_i && !busy_q;
        late      = (since_q >= SW'(REL_AT));
        enter     = rise && en_i && ref_ext_i && active_i && !kill_i && !hold_q && !late;
        release_o = hold_q && !kill_i && (late || !en_i || !ref_ext_i);
        bad_o     = rise && en_i && !ref_ext_i && active_i;
    end

    // Remember the previous busy level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= busy_i;
    end

    // Count cycles since the last forwarded start, saturating at the period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= SW'(PERIOD);
        else if (conv_go_i)
            since_q <= '0;
        else if (since_q < SW'(PERIOD))
            since_q <= since_q + 1'b1;
    end

    // Auto-doze hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (kill_i || release_o)
            hold_q <= 1'b0;
        else if (enter)
            hold_q <= 1'b1;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/pw_wake_seq.sv
// Top of the power-mode wake sequencer. It drives the light- and deep-sleep
// lines, gates convert-start on the ready flag and optionally dozes after
// each conversion. All delays are in clock cycles.
module pw_wake_seq
    import pw_seq_pkg::*;
#(
    parameter int unsigned NAP_WAKE_CYC    = 60,
    parameter int unsigned STBY_INT_CYC    = 100_000_000,
    parameter int unsigned STBY_EXT_CYC    = 16_000,
    parameter int unsigned CONV_PERIOD_CYC = 400,
    parameter bit          HAS_AUTO_NAP    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_req_i,
    input  logic       ref_ext_i,
    input  logic       auto_nap_i,
    input  logic       conv_req_i,
    input  logic       busy_i,
    output logic       nap_o,
    output logic       stby_o,
    output logic       ready_o,
    output logic       conv_go_o,
    output logic       err_o
);

    localparam int unsigned MAX_A = (STBY_INT_CYC > STBY_EXT_CYC) ? STBY_INT_CYC : STBY_EXT_CYC;
    localparam int unsigned MAX_D = (MAX_A > NAP_WAKE_CYC) ? MAX_A : NAP_WAKE_CYC;
    localparam int unsigned CW    = $clog2(MAX_D + 1);

    pw_state_t      state;
    pw_state_t      next_state;
    logic           wake_load;
    logic [CW-1:0]  wake_val;
    logic           an_hold;
    logic           an_release;
    logic           an_bad;
    logic           active;
    logic           kill;
    logic           t_load;
    logic [CW-1:0]  t_val;
    logic           t_busy;

    pw_state_ctrl #(
        .NAP_WAKE (NAP_WAKE_CYC),
        .STBY_INT (STBY_INT_CYC),
        .STBY_EXT (STBY_EXT_CYC),
        .CW       (CW)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (pwr_req_i),
        .ref_ext_i   (ref_ext_i),
        .bad_i       (an_bad),
        .state_o     (state),
        .next_o      (next_state),
        .wake_load_o (wake_load),
        .wake_val_o  (wake_val),
        .err_o       (err_o)
    );

    // Glue between state control, auto-doze and the wake timer.
    always_comb begin
        active    = (state == PW_ACTIVE);
        kill      = (next_state != PW_ACTIVE);
        t_load    = wake_load || an_release;
        t_val     = an_release ? CW'(NAP_WAKE_CYC) : wake_val;
        ready_o   = active && !t_busy && !an_hold;
        conv_go_o = conv_req_i && ready_o;
        nap_o     = (state == PW_NAP) || an_hold;
        stby_o    = (state == PW_STBY);
    end

    pw_wake_timer #(
        .CW (CW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (kill),
        .load_i (t_load),
        .val_i  (t_val),
        .busy_o (t_busy)
    );

    generate
        if (HAS_AUTO_NAP) begin : g_autonap
            pw_autonap #(
                .PERIOD   (CONV_PERIOD_CYC),
                .NAP_WAKE (NAP_WAKE_CYC)
            ) u_autonap (
                .clk       (clk),
                .rst_n     (rst_n),
                .en_i      (auto_nap_i),
                .ref_ext_i (ref_ext_i),
                .active_i  (active),
                .kill_i    (kill),
                .busy_i    (busy_i),
                .conv_go_i (conv_go_o),
                .hold_o    (an_hold),
                .release_o (an_release),
                .bad_o     (an_bad)
            );
        end else begin : g_no_autonap
            assign an_hold    = 1'b0;
            assign an_release = 1'b0;
            assign an_bad     = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pw_wake_seq_chk.sv
// Port-level checker for the wake sequencer, attached by bind.
module pw_wake_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_req_i,
    input logic       ref_ext_i,
    input logic       nap_o,
    input logic       stby_o,
    input logic       ready_o,
    input logic       err_o
);

    p_modes_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nap_o && stby_o));

    p_sleep_blocks_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nap_o || stby_o) |-> !ready_o);

    p_nap_exit_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nap_o) |-> !ready_o);

    p_stby_exit_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stby_o) |-> !ready_o);

    p_nap_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req_i == 2'b01 && !ref_ext_i && !nap_o) |=> (!nap_o && err_o));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind pw_wake_seq pw_wake_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_req_i (pwr_req_i),
    .ref_ext_i (ref_ext_i),
    .nap_o     (nap_o),
    .stby_o    (stby_o),
    .ready_o   (ready_o),
    .err_o     (err_o)
);

// File: tb/tb_pw_wake_seq.sv
`timescale 1ns/100ps
module tb_pw_wake_seq;

    localparam int NW  = 4;
    localparam int SI  = 12;
    localparam int SE  = 7;
    localparam int PER = 20;
    localparam int CUT = PER - NW - 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = 2'b00;
    logic       ref_ext = 1'b0;
    logic       auto_en = 1'b0;
    logic       conv_req = 1'b0;
    logic       busy = 1'b0;
    logic       nap, stby, ready, go, err;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pw_wake_seq #(
        .NAP_WAKE_CYC    (NW),
        .STBY_INT_CYC    (SI),
        .STBY_EXT_CYC    (SE),
        .CONV_PERIOD_CYC (PER),
        .HAS_AUTO_NAP    (1'b1)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pwr_req_i (req), .ref_ext_i (ref_ext),
        .auto_nap_i (auto_en), .conv_req_i (conv_req), .busy_i (busy),
        .nap_o (nap), .stby_o (stby), .ready_o (ready), .conv_go_o (go), .err_o (err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 2'b00; auto_en = 1'b0; conv_req = 1'b0; busy = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk("R1 nap", nap, 0);
        chk("R1 stby", stby, 0);
        chk("R1 ready", ready, 1);
        chk("R1 err", err, 0);
        chk("R1 go", go, 0);
    endtask

    // Enter a sleep state, then request running and time the wake (R3/R4/R5).
    task automatic wake_seq(input logic [1:0] from, input int n, input string tag);
        req = from;
        tick();
        chk("R2 nap line", nap, (from == 2'b01) ? 1 : 0);
        chk("R2 stby line", stby, (from == 2'b01) ? 0 : 1);
        chk("R2 ready low", ready, 0);
        repeat (3) tick();
        req = 2'b00;
        for (int k = 1; k <= n + 1; k++) begin
            tick();
            conv_req = 1'b1;
            #1;
            chk(tag, ready, (k == n + 1) ? 1 : 0);
            chk("R6 gated go", go, (k == n + 1) ? 1 : 0);
            if (k == 1) begin
                chk("R2 lines off", nap | stby, 0);
            end
            conv_req = 1'b0;
        end
    endtask

    initial begin
        do_reset();

        // Sweep every sleep code against both reference sources.
        for (int r = 0; r < 2; r++) begin
            for (int f = 1; f < 4; f++) begin
                ref_ext = r[0];
                if (f == 1 && r == 0) begin
                    req = 2'b01;
                    tick();
                    chk("R7 nap refused", nap, 0);
                    chk("R7 err set", err, 1);
                    chk("R7 still ready", ready, 1);
                    req = 2'b00;
                    tick();
                end else begin
                    wake_seq(f[1:0], (f == 1) ? NW : (r == 1 ? SE : SI),
                             (f == 1) ? "R3 nap wake" : (r == 1 ? "R5 ext wake" : "R4 int wake"));
                end
            end
        end
        chk("R8 err sticky", err, 1);
        repeat (5) tick();
        chk("R8 err still set", err, 1);

        // Auto-doze timing against the conversion period (R9, R10).
        do_reset();
        ref_ext = 1'b1; auto_en = 1'b1;
        tick();
        conv_req = 1'b1;
        #1;
        chk("R6 go when ready", go, 1);
        tick();
        conv_req = 1'b0;
        busy = 1'b1;
        for (int k = 1; k <= PER - 1; k++) begin
            tick();
            if (k == 3) busy = 1'b0;
            chk("R9 auto nap line", nap, (k <= CUT) ? 1 : 0);
            chk("R10 period ready", ready, (k == PER - 1) ? 1 : 0);
        end

        // Busy rise swept around the cut-off, then release by dropping enable (R11, R14).
        for (int pos = CUT - 2; pos <= CUT + 1; pos++) begin
            conv_req = 1'b1;
            tick();
            conv_req = 1'b0;
            repeat (pos) tick();
            busy = 1'b1;
            tick();
            busy = 1'b0;
            chk("R11 entry vs cut-off", nap, (pos < CUT) ? 1 : 0);
            auto_en = 1'b0;
            tick();
            auto_en = 1'b1;
            chk("R14 nap released", nap, 0);
            chk("R14 ready after drop", ready, (pos < CUT) ? 0 : 1);
            repeat (NW) tick();
            chk("R14 ready restored", ready, 1);
        end

        // Deep-sleep request in the same cycle as a busy rise (R13).
        conv_req = 1'b1;
        tick();
        conv_req = 1'b0;
        busy = 1'b1;
        req = 2'b10;
        tick();
        chk("R13 stby wins", stby, 1);
        chk("R13 no nap", nap, 0);
        busy = 1'b0;
        req = 2'b00;
        for (int k = 1; k <= SE + 1; k++) begin
            tick();
            chk("R13 ext wake", ready, (k == SE + 1) ? 1 : 0);
        end

        // Auto-doze with on-chip reference (R12).
        do_reset();
        ref_ext = 1'b0; auto_en = 1'b1;
        tick();
        busy = 1'b1;
        tick();
        busy = 1'b0;
        chk("R12 no nap", nap, 0);
        chk("R12 err set", err, 1);
        chk("R12 ready kept", ready, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-wide: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule